// File: doc/BRIEF.md
# Per-Bank Access Gap Timer

This block keeps a minimum idle gap between two accesses to the same memory bank. A typical use is to meet a row precharge time. There is one down-counter for each chip-select region that the memory sequencer serves. When the sequencer executes a pattern word whose timer-start bit is set, it pulses the arm strobe with the region index, and that region's counter starts.

While a region's counter is running, a new transfer start aimed at that region raises the stall output in the same cycle. The sequencer then inserts wait states and starts the pattern only once the stall has dropped. Transfers to any other region are not affected.

The gap length comes from a 2-bit period setting, giving 1 to 4 cycles. Any longer gap has to be written as extra words in the pattern itself.

Top module: `bank_gap_timer`

## Requirements
- R1: The period setting selects the number of blocked cycles after an arm edge: code 0 gives 1 cycle, code 1 gives 2, code 2 gives 3 and code 3 gives 4. The blocked cycles are the ones that directly follow the clock edge that samples the arm strobe.
- R2: An arm strobe blocks only the region named by `arm_region`.
- R3: While a region is blocked, a transfer start (`xfer_start` high) whose `xfer_region` names that region drives `stall` high in the same cycle.
- R4: Once the blocked cycles have elapsed, a transfer start to the region sees `stall` low.
- R5: A transfer start to a region that is not blocked never stalls, even while other regions are blocked.
- R6: An arm strobe for a region that is still blocked restarts its count with the full period sampled at that edge.
- R7: After reset no region is blocked.
- R8: `stall` is low in every cycle in which `xfer_start` is low.
- R9: The period setting is sampled only at the arm edge. Changing it while a count runs does not change that count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| period_sel | input | 2 | Gap length code (cycles minus one) |
| arm_valid | input | 1 | Start-timer strobe from the executing pattern word |
| arm_region | input | IDX_W | Region whose timer is started |
| xfer_start | input | 1 | A new transfer is requested this cycle |
| xfer_region | input | IDX_W | Target region of the requested transfer |
| stall | output | 1 | Target region is blocked; insert wait states |

## Verification
Each period code is tried by arming one region and then probing it in every following cycle. This separates an off-by-one in the load value from an off-by-one in the expiry.

Probing a neighbouring region while the armed one counts down tells per-region timers apart from a shared one. A rearm mid-count and a period change mid-count show whether the reload uses the full, freshly sampled period.

Idle cycles without a transfer start check that a busy region by itself raises nothing. A long pseudo-random run with overlapping arms and probes is then compared cycle by cycle against the bench's behavioural model.

// File: rtl/bgt_pkg.sv
package bgt_pkg;
    localparam int PER_W   = 2;
    localparam int MAX_GAP = 1 << PER_W;
    localparam int CNT_W   = $clog2(MAX_GAP + 1);

    typedef logic [CNT_W-1:0] gap_cnt_t;
    typedef logic [PER_W-1:0] period_t;

    typedef struct packed {
        gap_cnt_t remain;
    } ctr_state_t;

    function automatic gap_cnt_t period_to_load(input period_t code);
        return gap_cnt_t'(code) + gap_cnt_t'(1);
    endfunction
endpackage

// File: rtl/bgt_region_ctr.sv
module bgt_region_ctr
    import bgt_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     load,
    input  gap_cnt_t load_val,
    output logic     busy
);
    ctr_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (load) begin
            state_d.remain = load_val;
        end else if (state_q.remain != '0) begin
            state_d.remain = state_q.remain - gap_cnt_t'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign busy = (state_q.remain != '0);
endmodule

// File: rtl/bgt_stall_sel.sv
module bgt_stall_sel #(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  logic [N-1:0]     busy,
    input  logic             xfer_start,
    input  logic [IDX_W-1:0] xfer_region,
    output logic             stall
);
    localparam int SLOTS = 1 << IDX_W;

    logic [SLOTS-1:0] padded;

    always_comb begin
        padded        = '0;
        padded[N-1:0] = busy;
        stall         = xfer_start & padded[xfer_region];
    end
endmodule

// File: rtl/bank_gap_timer.sv
module bank_gap_timer #(
    parameter int NUM_REGIONS = 4,
    localparam int IDX_W      = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       period_sel,
    input  logic             arm_valid,
    input  logic [IDX_W-1:0] arm_region,
    input  logic             xfer_start,
    input  logic [IDX_W-1:0] xfer_region,
    output logic             stall
);
    import bgt_pkg::*;

    gap_cnt_t               load_val;
    logic [NUM_REGIONS-1:0] region_busy;

    assign load_val = period_to_load(period_t'(period_sel));

    for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_region
        logic load_r;
        assign load_r = arm_valid && (arm_region == IDX_W'(r));

        bgt_region_ctr u_ctr (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (load_r),
            .load_val (load_val),
            .busy     (region_busy[r])
        );
    end

    bgt_stall_sel #(
        .N     (NUM_REGIONS),
        .IDX_W (IDX_W)
    ) u_sel (
        .busy        (region_busy),
        .xfer_start  (xfer_start),
        .xfer_region (xfer_region),
        .stall       (stall)
    );
endmodule

// File: rtl/bgt_checker.sv
module bgt_checker #(
    parameter int N       = 4,
    parameter int IDX_W   = 2,
    parameter int MAX_GAP = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             arm_valid,
    input logic [IDX_W-1:0] arm_region,
    input logic             xfer_start,
    input logic [IDX_W-1:0] xfer_region,
    input logic             stall,
    input logic [N-1:0]     busy
);
    localparam int RUN_W = $clog2(MAX_GAP + 2) + 1;

    AST_NO_STALL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_start |-> !stall); // R8

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !stall); // R7

    AST_ARM_THEN_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        arm_valid ##1 (xfer_start && xfer_region == $past(arm_region)) |-> stall); // R3

    for (genvar r = 0; r < N; r++) begin : g_chk
        logic [RUN_W-1:0] run_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                run_q <= '0;
            end else if (arm_valid && arm_region == IDX_W'(r)) begin
                run_q <= RUN_W'(1);
            end else if (busy[r] && run_q != '1) begin
                run_q <= run_q + RUN_W'(1);
            end else if (!busy[r]) begin
                run_q <= '0;
            end
        end

        AST_GAP_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
            busy[r] |-> (run_q != '0 && run_q <= RUN_W'(MAX_GAP))); // R1

        AST_ONLY_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(busy[r]) |-> $past(arm_valid && arm_region == IDX_W'(r))); // R2
    end
endmodule

bind bank_gap_timer bgt_checker #(
    .N       (NUM_REGIONS),
    .IDX_W   (IDX_W),
    .MAX_GAP (bgt_pkg::MAX_GAP)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .arm_valid   (arm_valid),
    .arm_region  (arm_region),
    .xfer_start  (xfer_start),
    .xfer_region (xfer_region),
    .stall       (stall),
    .busy        (region_busy)
);

// File: tb/bank_gap_timer_bench.sv
module bank_gap_timer_bench;
    localparam int NR = 4;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] period_sel;
    logic       arm_valid;
    logic [1:0] arm_region;
    logic       xfer_start;
    logic [1:0] xfer_region;
    logic       stall;

    int checks = 0;
    int errors = 0;
    int model_cnt [NR];
    bit finished = 0;

    always #4 clk = ~clk;

    bank_gap_timer #(.NUM_REGIONS(NR)) u_bank_gap_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .period_sel  (period_sel),
        .arm_valid   (arm_valid),
        .arm_region  (arm_region),
        .xfer_start  (xfer_start),
        .xfer_region (xfer_region),
        .stall       (stall)
    );

    // behavioural reference, updated at every rising edge
    always @(posedge clk) begin
        for (int r = 0; r < NR; r++) begin
            if (!rst_n) model_cnt[r] = 0;
            else if (arm_valid && int'(arm_region) == r) model_cnt[r] = int'(period_sel) + 1;
            else if (model_cnt[r] > 0) model_cnt[r] = model_cnt[r] - 1;
        end
    end

    task automatic step(input bit av, input int ar, input int per,
                        input bit xs, input int xr, input string tag);
        bit exp;
        @(negedge clk);
        arm_valid   = av;
        arm_region  = 2'(ar);
        period_sel  = 2'(per);
        xfer_start  = xs;
        xfer_region = 2'(xr);
        #1;
        exp = xs && (model_cnt[xr] > 0);
        checks++;
        if (stall !== exp) begin
            errors++;
            $display("FAIL %s: stall=%0b expected=%0b (region %0d)", tag, stall, exp, xr);
        end
    endtask

    initial begin
        rst_n = 1'b0;
        arm_valid = 0; arm_region = 0; period_sel = 0; xfer_start = 0; xfer_region = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R7: every region clear after reset
        for (int r = 0; r < NR; r++) step(0, 0, 0, 1, r, "R7");

        // R1 R3 R4: each period code, probe the armed region every cycle
        for (int p = 0; p < 4; p++) begin
            step(1, 0, p, 0, 0, "R1");
            for (int k = 0; k < 6; k++) step(0, 0, 0, 1, 0, (k <= p) ? "R3" : "R4");
        end

        // R2 R5: arm region 1, probe regions 2, 0, 3 and then 1
        step(1, 1, 3, 0, 0, "R2");
        step(0, 0, 0, 1, 2, "R5");
        step(0, 0, 0, 1, 0, "R5");
        step(0, 0, 0, 1, 3, "R2");
        step(0, 0, 0, 1, 1, "R3");
        repeat (3) step(0, 0, 0, 0, 0, "R8");

        // R6: rearm mid-count reloads the full period
        step(1, 2, 3, 0, 0, "R6");
        step(0, 0, 0, 1, 2, "R6");
        step(0, 0, 0, 1, 2, "R6");
        step(1, 2, 3, 0, 0, "R6");
        for (int k = 0; k < 6; k++) step(0, 0, 0, 1, 2, "R6");

        // R9: period change mid-count leaves the running count alone
        step(1, 3, 0, 0, 0, "R9");
        for (int k = 0; k < 3; k++) step(0, 0, 3, 1, 3, "R9");

        // R8: busy region, no transfer start
        step(1, 0, 3, 0, 0, "R8");
        for (int k = 0; k < 4; k++) step(0, 0, 2, 0, 0, "R8");

        // mixed pseudo-random traffic
        begin
            logic [15:0] lf = 16'hACE1;
            for (int i = 0; i < 400; i++) begin
                lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                step(lf[0] & lf[5], int'(lf[2:1]), int'(lf[4:3]), lf[6], int'(lf[8:7]), "R3");
            end
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule